// File: doc/BRIEF.md
# BCD Calendar Counter

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day of month, weekday, month, a two-digit year and a century bit, all stored as packed BCD except the weekday, which is a plain binary count. A divide-by-2^N prescaler turns a fast enable input into one increment per second. The increment ripples through the fields with the correct month lengths and a leap rule taken from the two-digit year.

Software reaches the fields through a small register port. Each field sits at one address, and a write takes effect on the clock edge. The read data always shows the field that `addr` selects. Holding `rd_en` high freezes every counter, so a multi-byte read stays consistent even when a carry arrives during it. One tick that arrives during the freeze is kept and applied once the freeze ends. A stop input clears the prescaler and halts timekeeping. A sticky validity flag, bit 7 of the seconds byte, records that the supply dipped. It stays set until software writes it to 0.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the fields read seconds 0x80 (validity flag set, seconds 00), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 and year 0x00.
- R2: Address map: 0 seconds {flag, sec[6:0]}, 1 minutes, 2 hours (bits 5:0), 3 day (bits 5:0), 4 weekday (bits 2:0), 5 month {century, 00, month[4:0]}, 6 year. Unused bits and address 7 read 0.
- R3: Seconds and minutes count 00 to 59 in BCD. A wrap from 59 to 00 carries into the next field.
- R4: Hours count 00 to 23 in BCD. The step from 23:59:59 gives 00:00:00 and advances the date by one day.
- R5: The day counts from 01 up to the month length and then wraps to 01 and advances the month. The month length is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11.
- R6: February has 29 days when the two-digit year is divisible by 4, year 00 included, and 28 days otherwise.
- R7: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00 and toggles the century bit (bit 7 of the month byte).
- R8: The weekday (bits 2:0) advances with each day carry and wraps from 6 to 0.
- R9: While `rd_en` is high no counter changes. One tick that arrives during the freeze is applied on the first edge after the freeze ends, and later ticks keep their normal phase.
- R10: While `stop` is high the prescaler is held at zero and no field advances. After `stop` falls, the first increment comes exactly 2^DIV_STAGES enabled cycles later.
- R11: A write to any address clears the prescaler and any pending tick. The next increment comes exactly 2^DIV_STAGES enabled cycles after the write edge.
- R12: `volt_low` high sets the validity flag on the next edge. The flag stays set until a write to address 0 with bit 7 = 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 1 | Prescaler input enable, one pulse per source period |
| stop | input | 1 | Clears the prescaler and halts timekeeping |
| volt_low | input | 1 | Supply-low indication, sets the validity flag |
| rd_en | input | 1 | Read in progress; freezes the counters |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Field address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed field |

## Verification
The main test loads 23:59:59 and then sweeps every month across years 00, 01, 02, 04, 96, 98 and 99. Each date is tried twice: once on the last day of the month, and once on the day before it. This separates early wraps, missed wraps, a wrong February length, a missing century toggle and the year-end carry. A free run of 130 seconds and a 00:59:58 start check the seconds-to-minutes-to-hours chain. Freeze, stop and write are each sampled cycle by cycle around the tick edge. These checks show whether a tick is lost, doubled, or comes at the wrong phase.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int FIELD_AW = 3;

  localparam logic [FIELD_AW-1:0] FLD_SEC   = 3'd0;
  localparam logic [FIELD_AW-1:0] FLD_MIN   = 3'd1;
  localparam logic [FIELD_AW-1:0] FLD_HOUR  = 3'd2;
  localparam logic [FIELD_AW-1:0] FLD_DAY   = 3'd3;
  localparam logic [FIELD_AW-1:0] FLD_WDAY  = 3'd4;
  localparam logic [FIELD_AW-1:0] FLD_MONTH = 3'd5;
  localparam logic [FIELD_AW-1:0] FLD_YEAR  = 3'd6;

  localparam logic [2:0] WDAY_LAST = 3'd6;

  // Add one to a two-digit packed BCD value (no wrap handling).
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'h9) r = {v[7:4] + 4'h1, 4'h0};
    else                r = {v[7:4], v[3:0] + 4'h1};
    return r;
  endfunction

  // Two-digit BCD year divisible by 4: tens even -> ones 0/4/8, tens odd -> ones 2/6.
  function automatic logic is_leap(input logic [7:0] yr);
    logic r;
    if (yr[4] == 1'b0) r = (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
    else               r = (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
    return r;
  endfunction

  // Last day of a month, in BCD.
  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] r;
    case (mon)
      8'h02:                      r = is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int STAGES = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_en,
  input  logic clr,
  output logic tick
);

  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_d;
  logic [STAGES:0]   en_chain;

  assign en_chain[0] = src_en;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign en_chain[i+1] = en_chain[i] & cnt_q[i];
    assign cnt_d[i]      = clr ? 1'b0 : (cnt_q[i] ^ en_chain[i]);
  end

  assign tick = en_chain[STAGES] & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import bcd_cal_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                ld_en,
  input  logic [FIELD_AW-1:0] ld_sel,
  input  logic [6:0]          ld_data,
  output logic [6:0]          sec,
  output logic [6:0]          min,
  output logic [5:0]          hour,
  output logic                day_step
);

  logic [6:0] sec_q, sec_d;
  logic [6:0] min_q, min_d;
  logic [5:0] hr_q,  hr_d;
  logic       sec_wrap, min_wrap, hr_wrap;

  assign sec_wrap = (sec_q == 7'h59);
  assign min_wrap = (min_q == 7'h59);
  assign hr_wrap  = (hr_q  == 6'h23);
  assign day_step = step & ~ld_en & sec_wrap & min_wrap & hr_wrap;

  always_comb begin
    sec_d = sec_q;
    min_d = min_q;
    hr_d  = hr_q;
    if (ld_en) begin
      case (ld_sel)
        FLD_SEC:  sec_d = ld_data;
        FLD_MIN:  min_d = ld_data;
        FLD_HOUR: hr_d  = ld_data[5:0];
        default:  ;
      endcase
    end else if (step) begin
      if (sec_wrap) begin
        sec_d = '0;
        if (min_wrap) begin
          min_d = '0;
          hr_d  = hr_wrap ? '0 : 6'(bcd_inc8({2'b00, hr_q}));
        end else begin
          min_d = 7'(bcd_inc8({1'b0, min_q}));
        end
      end else begin
        sec_d = 7'(bcd_inc8({1'b0, sec_q}));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
    end else begin
      sec_q <= sec_d;
      min_q <= min_d;
      hr_q  <= hr_d;
    end
  end

  assign sec  = sec_q;
  assign min  = min_q;
  assign hour = hr_q;

endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import bcd_cal_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                day_step,
  input  logic                ld_en,
  input  logic [FIELD_AW-1:0] ld_sel,
  input  logic [7:0]          ld_data,
  output logic [5:0]          day,
  output logic [2:0]          wday,
  output logic [4:0]          month,
  output logic [7:0]          year,
  output logic                century
);

  logic [5:0] day_q,  day_d;
  logic [2:0] wd_q,   wd_d;
  logic [4:0] mon_q,  mon_d;
  logic [7:0] yr_q,   yr_d;
  logic       cen_q,  cen_d;
  logic [7:0] last_day;

  assign last_day = month_days({3'b000, mon_q}, yr_q);

  always_comb begin
    day_d = day_q;
    wd_d  = wd_q;
    mon_d = mon_q;
    yr_d  = yr_q;
    cen_d = cen_q;
    if (ld_en) begin
      case (ld_sel)
        FLD_DAY:   day_d = ld_data[5:0];
        FLD_WDAY:  wd_d  = ld_data[2:0];
        FLD_MONTH: begin
          mon_d = ld_data[4:0];
          cen_d = ld_data[7];
        end
        FLD_YEAR:  yr_d  = ld_data;
        default:   ;
      endcase
    end else if (day_step) begin
      wd_d = (wd_q == WDAY_LAST) ? 3'd0 : wd_q + 3'd1;
      if ({2'b00, day_q} == last_day) begin
        day_d = 6'h01;
        if (mon_q == 5'h12) begin
          mon_d = 5'h01;
          if (yr_q == 8'h99) begin
            yr_d  = 8'h00;
            cen_d = ~cen_q;
          end else begin
            yr_d  = bcd_inc8(yr_q);
          end
        end else begin
          mon_d = 5'(bcd_inc8({3'b000, mon_q}));
        end
      end else begin
        day_d = 6'(bcd_inc8({2'b00, day_q}));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day_q <= 6'h01;
      wd_q  <= 3'd0;
      mon_q <= 5'h01;
      yr_q  <= 8'h00;
      cen_q <= 1'b0;
    end else begin
      day_q <= day_d;
      wd_q  <= wd_d;
      mon_q <= mon_d;
      yr_q  <= yr_d;
      cen_q <= cen_d;
    end
  end

  assign day     = day_q;
  assign wday    = wd_q;
  assign month   = mon_q;
  assign year    = yr_q;
  assign century = cen_q;

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import bcd_cal_pkg::*;
#(
  parameter int DIV_STAGES = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_en,
  input  logic       stop,
  input  logic       volt_low,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);

  logic       tick;
  logic       presc_clr;
  logic       pend_q, pend_d;
  logic       vl_q, vl_d;
  logic       step;
  logic       day_step;
  logic [6:0] sec_q, min_q;
  logic [5:0] hour_q, day_q;
  logic [2:0] wday_q;
  logic [4:0] month_q;
  logic [7:0] year_q;
  logic       cent_q;

  assign presc_clr = stop | wr_en;

  cal_prescaler #(.STAGES(DIV_STAGES)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_en (src_en),
    .clr    (presc_clr),
    .tick   (tick)
  );

  // Freeze handling: one held tick, released on the first unfrozen edge.
  always_comb begin
    step   = 1'b0;
    pend_d = pend_q;
    if (presc_clr) begin
      pend_d = 1'b0;
    end else if (rd_en) begin
      pend_d = pend_q | tick;
    end else begin
      step   = pend_q | tick;
      pend_d = pend_q & tick;
    end
  end

  always_comb begin
    vl_d = vl_q;
    if (volt_low)                        vl_d = 1'b1;
    else if (wr_en && (addr == FLD_SEC)) vl_d = wdata[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vl_q   <= 1'b1;
    end else begin
      pend_q <= pend_d;
      vl_q   <= vl_d;
    end
  end

  cal_time_chain u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .ld_en    (wr_en),
    .ld_sel   (addr),
    .ld_data  (wdata[6:0]),
    .sec      (sec_q),
    .min      (min_q),
    .hour     (hour_q),
    .day_step (day_step)
  );

  cal_date_chain u_date (
    .clk      (clk),
    .rst_n    (rst_n),
    .day_step (day_step),
    .ld_en    (wr_en),
    .ld_sel   (addr),
    .ld_data  (wdata),
    .day      (day_q),
    .wday     (wday_q),
    .month    (month_q),
    .year     (year_q),
    .century  (cent_q)
  );

  always_comb begin
    case (addr)
      FLD_SEC:   rdata = {vl_q, sec_q};
      FLD_MIN:   rdata = {1'b0, min_q};
      FLD_HOUR:  rdata = {2'b00, hour_q};
      FLD_DAY:   rdata = {2'b00, day_q};
      FLD_WDAY:  rdata = {5'b00000, wday_q};
      FLD_MONTH: rdata = {cent_q, 2'b00, month_q};
      FLD_YEAR:  rdata = year_q;
      default:   rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/cal_core_checker.sv
module cal_core_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       wr_en,
  input logic       stop,
  input logic       volt_low,
  input logic       step,
  input logic       vl,
  input logic [6:0] sec,
  input logic [6:0] min,
  input logic [5:0] hour,
  input logic [5:0] day,
  input logic [2:0] wday,
  input logic [4:0] month,
  input logic [7:0] year,
  input logic       cent
);

  // R3: seconds wrap 59 -> 00 on an increment
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && sec == 7'h59) |=> (sec == 7'h00));

  // R4: hours wrap 23 -> 00 at the end of the day
  a_r4_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && sec == 7'h59 && min == 7'h59 && hour == 6'h23) |=> (hour == 6'h00));

  // R7: the year-end carry flips the century bit
  a_r7_century: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && sec == 7'h59 && min == 7'h59 && hour == 6'h23 &&
     day == 6'h31 && month == 5'h12 && year == 8'h99) |=> (cent != $past(cent)));

  // R8: weekday never passes 6
  a_r8_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wday == 3'd6 && !wr_en) |=> (wday == 3'd6 || wday == 3'd0));

  // R9: counters hold while a read is in progress
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> $stable({sec, min, hour, day, wday, month, year, cent}));

  // R10: no advance while stopped
  a_r10_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_en) |=> $stable({sec, min, hour, day, wday, month, year, cent}));

  // R12: the supply-low input sets the flag
  a_r12_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    volt_low |=> vl);

  // R12: the flag only falls through a write
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (vl && !wr_en) |=> vl);

endmodule

bind bcd_calendar_core cal_core_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .stop     (stop),
  .volt_low (volt_low),
  .step     (step),
  .vl       (vl_q),
  .sec      (sec_q),
  .min      (min_q),
  .hour     (hour_q),
  .day      (day_q),
  .wday     (wday_q),
  .month    (month_q),
  .year     (year_q),
  .cent     (cent_q)
);

// File: tb/bcd_calendar_core_tb_top.sv
`timescale 1ns/100ps
module bcd_calendar_core_tb_top;

  localparam int STAGES = 2;
  localparam int PERIOD = 1 << STAGES;

  logic       clk;
  logic       rst_n;
  logic       src_en;
  logic       stop;
  logic       volt_low;
  logic       rd_en;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;

  int n_checks;
  int n_errors;
  bit done;

  bcd_calendar_core #(.DIV_STAGES(STAGES)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .stop(stop), .volt_low(volt_low),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // Called at a negedge; leaves the strobe down at the next negedge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int yrs[7];
    yrs = '{0, 1, 2, 4, 96, 98, 99};
    n_checks = 0; n_errors = 0; done = 1'b0;
    rst_n = 1'b0; src_en = 1'b0; stop = 1'b0; volt_low = 1'b0;
    rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 layout
    peek(3'd0, v); check("R1 sec", v, 8'h80);
    peek(3'd1, v); check("R1 min", v, 8'h00);
    peek(3'd2, v); check("R1 hour", v, 8'h00);
    peek(3'd3, v); check("R1 day", v, 8'h01);
    peek(3'd4, v); check("R1 wday", v, 8'h00);
    peek(3'd5, v); check("R1 month", v, 8'h01);
    peek(3'd6, v); check("R1 year", v, 8'h00);
    peek(3'd7, v); check("R2 addr7", v, 8'h00);

    src_en = 1'b1;

    // R12 flag: write clears, input sets, stays set
    wr(3'd0, 8'h00);
    peek(3'd0, v); check("R12 cleared", v & 8'h80, 8'h00);
    volt_low = 1'b1; @(negedge clk); volt_low = 1'b0;
    peek(3'd0, v); check("R12 set", v & 8'h80, 8'h80);
    repeat (10) @(negedge clk);
    peek(3'd0, v); check("R12 sticky", v & 8'h80, 8'h80);
    wr(3'd0, 8'h00);
    peek(3'd0, v); check("R12 write0", v & 8'h80, 8'h00);

    // R3 free run of 130 seconds from midnight
    wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h00);
    repeat (130 * PERIOD) @(negedge clk);
    peek(3'd0, v); check("R3 sec run", v, 8'h10);
    peek(3'd1, v); check("R3 min run", v, 8'h02);

    // R3/R4 minute into hour carry
    wr(3'd2, 8'h00); wr(3'd1, 8'h59); wr(3'd0, 8'h58);
    repeat (2 * PERIOD) @(negedge clk);
    peek(3'd0, v); check("R3 sec carry", v, 8'h00);
    peek(3'd1, v); check("R3 min carry", v, 8'h00);
    peek(3'd2, v); check("R4 hour carry", v, 8'h01);

    // R4..R8 date sweep at 23:59:59, last day and the day before
    foreach (yrs[yi]) begin
      for (int m = 1; m <= 12; m++) begin
        for (int last = 0; last < 2; last++) begin
          int y, dim, d0, w0;
          int e_day, e_mon, e_yr, e_cen;
          y = yrs[yi];
          dim = days_in(m, y);
          d0 = (last == 1) ? dim : dim - 1;
          w0 = (m + y) % 7;
          wr(3'd6, to_bcd(y));
          wr(3'd5, to_bcd(m));
          wr(3'd3, to_bcd(d0));
          wr(3'd4, 8'(w0));
          wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
          repeat (PERIOD) @(negedge clk);
          if (last == 1) begin
            e_day = 1;
            e_mon = (m == 12) ? 1 : m + 1;
            e_yr  = (m == 12) ? (y + 1) % 100 : y;
            e_cen = (m == 12 && y == 99) ? 1 : 0;
          end else begin
            e_day = dim; e_mon = m; e_yr = y; e_cen = 0;
          end
          peek(3'd2, v); check("R4 hour wrap", v, 8'h00);
          peek(3'd3, v); check((m == 2) ? "R6 feb day" : "R5 day", v, to_bcd(e_day));
          peek(3'd5, v); check("R7 month/century", v, 8'(e_cen << 7) | to_bcd(e_mon));
          peek(3'd6, v); check("R7 year", v, to_bcd(e_yr));
          peek(3'd4, v); check("R8 weekday", v, 8'((w0 + 1) % 7));
        end
      end
    end

    // R11 write restarts the prescaler; R9 freeze holds one tick
    wr(3'd0, 8'h10);              // write edge E0, now after E0
    repeat (2) @(negedge clk);    // after E2
    rd_en = 1'b1;                 // frozen across E3, E4, E5
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      peek(3'd0, v); check("R9 frozen", v, 8'h10);
    end
    rd_en = 1'b0;
    @(negedge clk);               // after E6: held tick applied
    peek(3'd0, v); check("R9 held tick", v, 8'h11);
    @(negedge clk);               // after E7
    peek(3'd0, v); check("R9 no double", v, 8'h11);
    @(negedge clk);               // after E8: normal phase
    peek(3'd0, v); check("R9 phase kept", v, 8'h12);

    wr(3'd0, 8'h20);
    repeat (PERIOD - 1) @(negedge clk);
    peek(3'd0, v); check("R11 not early", v, 8'h20);
    @(negedge clk);
    peek(3'd0, v); check("R11 on time", v, 8'h21);

    // R10 stop halts and restarts the prescaler
    @(negedge clk);
    stop = 1'b1;
    repeat (5 * PERIOD) @(negedge clk);
    peek(3'd0, v); check("R10 halted", v, 8'h21);
    stop = 1'b0;
    repeat (PERIOD - 1) @(negedge clk);
    peek(3'd0, v); check("R10 not early", v, 8'h21);
    @(negedge clk);
    peek(3'd0, v); check("R10 on time", v, 8'h22);

    finish_run();
  end

endmodule